// File: doc/BRIEF.md
# Dual-Group Dot-Matrix Column Scanner

This block refreshes a 32-character line of 5x7 dot-matrix characters. The line is split into a lower and an upper half of 16 positions each. Both halves are scanned together, so position p of the lower half and position p of the upper half (absolute position p+16) are lit at the same moment. On each start, the host places two 6-bit character codes and a 4-bit pair position on a 16-bit data bus and pulses a start line. The block then steps through the five columns of that character pair and drives seven row lines per half.

There is a single character-pattern lookup, and the two halves share it in time. In the blank cycle before each column, the lookup is fed the lower code and its result is latched for the lower half. While the column is lit, the lookup is fed the upper code straight from the live bus. The host must therefore hold the upper code stable for as long as the column is lit. After the fifth column the last column stays lit until one of three things happens: a new start arrives, a guard interval runs out, or a clear is issued. The guard interval keeps the LEDs from being held on when the host stops scanning.

Top module: `dual_group_scan`

## Requirements
- R1: While reset is applied and just after it is released, all row lines and column selects are 0, `pos_sel` is 0 and `busy` is 0.
- R2: The bus fields are: `bus_data[5:0]` is the lower-half code, `bus_data[11:6]` is the upper-half code and `bus_data[15:12]` is the pair position. A start that is sampled while `busy` is 0 and `clr` is 0 latches the position into `pos_sel` and raises `busy`, both on the next cycle.
- R3: An accepted start first gives one blank cycle. Columns 0, 1, 2, 3 and 4 are then lit in that order, each for `COL_CYCLES` cycles, and `col_sel` bit c is the only bit set while column c is lit. Every column is preceded by exactly one blank cycle in which `col_sel` and both row buses are 0.
- R4: The pattern lookup computes row bits = (code + 9*column) mod 128.
- R5: `row_lo` shows the pattern of the lower code as sampled in the blank cycle before the column. Bus changes while the column is lit have no effect on it.
- R6: While a column is lit, `row_hi` shows the pattern of the upper code currently on the bus, in the same cycle.
- R7: `busy` is 1 from the cycle after an accepted start until the last lit cycle of column 4. A start that arrives while `busy` is 1 is ignored and does not change `pos_sel` or the scan.
- R8: After column 4, that column stays lit with `busy` at 0 for `GUARD_CYCLES` cycles, after which all drive is blanked. A start during this hold interval is accepted as in R2.
- R9: A `clr` sampled at an edge blanks all rows and column selects and drops `busy` from the next cycle. `clr` takes priority over a start in the same cycle, and `pos_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 16 | Two character codes and the pair position |
| start | input | 1 | Start pulse for a five-column scan |
| clr | input | 1 | Drops the scan and blanks the drive |
| row_lo | output | 7 | Row drive for the lower half |
| row_hi | output | 7 | Row drive for the upper half |
| col_sel | output | 5 | One-hot column select |
| pos_sel | output | 4 | Pair position being scanned |
| busy | output | 1 | Scan in progress |

## Verification
A start sampled at edge k shows up as `busy` and `pos_sel` after edge k. The first lit column appears after edge k+1, and each column then takes `COL_CYCLES`+1 cycles including its blank cycle. `row_hi` responds within the same cycle to a bus change, while `row_lo` only picks up the bus value present in a blank cycle. The bench drives inputs on the falling edge, compares every output one time unit later against a behavioural model that counts elapsed cycles since the start, and advances that model at each rising edge. This way every latency is checked on the cycle it is due. The stimulus includes a bus that changes every cycle, starts issued while busy and during the hold interval, and clears that coincide with starts.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_ON    = 2'd2,
        PH_HOLD  = 2'd3
    } scan_phase_e;

endpackage

// File: rtl/disp_glyph_lookup.sv
module disp_glyph_lookup #(
    parameter int CODE_W = 6,
    parameter int COL_W  = 3,
    parameter int ROWS   = 7
) (
    input  logic [CODE_W-1:0] code,
    input  logic [COL_W-1:0]  col,
    output logic [ROWS-1:0]   rows
);
    localparam int SW = ROWS + COL_W + CODE_W + 4;

    logic [SW-1:0] sum;

    always_comb begin
        sum  = SW'(code) + SW'(col) * SW'(9);
        rows = sum[ROWS-1:0];
    end

endmodule

// File: rtl/disp_phase_timer.sv
module disp_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (cnt_q != limit)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == limit);

    // R3/R8: a running interval never passes its limit
    p_count_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q <= limit) |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/dual_group_scan.sv
module dual_group_scan
    import disp_scan_pkg::*;
#(
    parameter int COL_CYCLES   = 11000,
    parameter int GUARD_CYCLES = 12500,
    parameter int NCOLS        = 5,
    parameter int ROWS         = 7,
    parameter int CODE_W       = 6,
    parameter int POS_W        = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*CODE_W+POS_W-1:0] bus_data,
    input  logic                      start,
    input  logic                      clr,
    output logic [ROWS-1:0]           row_lo,
    output logic [ROWS-1:0]           row_hi,
    output logic [NCOLS-1:0]          col_sel,
    output logic [POS_W-1:0]          pos_sel,
    output logic                      busy
);
    localparam int BUS_W   = 2*CODE_W + POS_W;
    localparam int COL_W   = (NCOLS > 1) ? $clog2(NCOLS) : 1;
    localparam int MAX_LIM = (COL_CYCLES > GUARD_CYCLES) ? COL_CYCLES : GUARD_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] LIM_COL   = CNT_W'(COL_CYCLES - 1);
    localparam logic [CNT_W-1:0] LIM_GUARD = CNT_W'(GUARD_CYCLES - 1);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(NCOLS - 1);

    typedef struct packed {
        scan_phase_e      ph;
        logic [COL_W-1:0] col;
        logic [POS_W-1:0] pos;
        logic [ROWS-1:0]  lo_rows;
    } scan_state_t;

    scan_state_t s_d, s_q;

    logic [CODE_W-1:0] code_lo, code_hi, lookup_code;
    logic [ROWS-1:0]   glyph_rows;
    logic              lit;
    logic              tmr_restart, tmr_exp;
    logic [CNT_W-1:0]  tmr_limit;

    assign code_lo = bus_data[CODE_W-1:0];
    assign code_hi = bus_data[2*CODE_W-1:CODE_W];

    // shared lookup: lower code in the blank cycle, live upper code otherwise
    assign lookup_code = (s_q.ph == PH_BLANK) ? code_lo : code_hi;

    disp_glyph_lookup #(
        .CODE_W(CODE_W),
        .COL_W (COL_W),
        .ROWS  (ROWS)
    ) u_lookup (
        .code(lookup_code),
        .col (s_q.col),
        .rows(glyph_rows)
    );

    assign tmr_limit   = (s_q.ph == PH_HOLD) ? LIM_GUARD : LIM_COL;
    assign tmr_restart = (s_q.ph == PH_IDLE) || (s_q.ph == PH_BLANK) ||
                         ((s_q.ph == PH_ON) && tmr_exp);

    disp_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .limit  (tmr_limit),
        .expired(tmr_exp)
    );

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.ph = PH_IDLE;
        end else begin
            unique case (s_q.ph)
                PH_IDLE, PH_HOLD: begin
                    if (start) begin
                        s_d.ph  = PH_BLANK;
                        s_d.col = '0;
                        s_d.pos = bus_data[BUS_W-1:2*CODE_W];
                    end else if (s_q.ph == PH_HOLD && tmr_exp) begin
                        s_d.ph = PH_IDLE;
                    end
                end
                PH_BLANK: begin
                    s_d.lo_rows = glyph_rows;
                    s_d.ph      = PH_ON;
                end
                PH_ON: begin
                    if (tmr_exp) begin
                        if (s_q.col == LAST_COL) begin
                            s_d.ph = PH_HOLD;
                        end else begin
                            s_d.col = s_q.col + COL_W'(1);
                            s_d.ph  = PH_BLANK;
                        end
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, col: '0, pos: '0, lo_rows: '0};
        else        s_q <= s_d;
    end

    assign lit     = (s_q.ph == PH_ON) || (s_q.ph == PH_HOLD);
    assign row_lo  = lit ? s_q.lo_rows : '0;
    assign row_hi  = lit ? glyph_rows  : '0;
    assign pos_sel = s_q.pos;
    assign busy    = (s_q.ph == PH_BLANK) || (s_q.ph == PH_ON);

    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        assign col_sel[c] = lit && (s_q.col == COL_W'(c));
    end

    // R3: at most one column driven at a time
    p_col_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel));

    // R3: a lit column either stays or goes dark; never jumps to another column
    p_col_via_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel != '0) |=> (col_sel == '0 || col_sel == $past(col_sel)));

    // R2: an accepted start latches the position and raises busy
    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clr) |=> (busy && pos_sel == $past(bus_data[BUS_W-1:2*CODE_W])));

    // R7: a start during a scan leaves the position untouched
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !clr) |=> $stable(pos_sel));

    // R5: the lower half does not move while its column stays lit
    p_lo_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel != '0) |=> (col_sel == '0 || $stable(row_lo)));

    // R9: clear blanks everything on the next cycle
    p_clear_blanks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (col_sel == '0 && row_lo == '0 && row_hi == '0 && !busy));

endmodule

// File: tb/dual_group_scan_test.sv
module dual_group_scan_test;
    localparam int C = 3;
    localparam int G = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        start = 1'b0;
    logic        clr = 1'b0;
    logic [6:0]  row_lo, row_hi;
    logic [4:0]  col_sel;
    logic [3:0]  pos_sel;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference: mode 0 idle, 1 scanning, 2 hold
    int m_mode = 0, m_el = 0, m_hold = 0, m_pos = 0, m_lo = 0;
    int seed = 7;
    string ctx = "R1";

    always #4 clk = ~clk;

    dual_group_scan #(.COL_CYCLES(C), .GUARD_CYCLES(G)) uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .start(start), .clr(clr),
        .row_lo(row_lo), .row_hi(row_hi), .col_sel(col_sel), .pos_sel(pos_sel), .busy(busy)
    );

    function automatic int glyph(int code, int col);
        return (code + 9 * col) % 128;   // R4
    endfunction

    task automatic chk(string req, string sig, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s (%s) at %0t: got %0h expected %0h", req, sig, ctx, $time, got, exp);
        end
    endtask

    task automatic compare();
        int col, sub;
        bit lit;
        col = 0; lit = 0;
        if (m_mode == 1) begin
            col = m_el / (C + 1);
            sub = m_el % (C + 1);
            lit = (sub != 0);
        end else if (m_mode == 2) begin
            col = 4;
            lit = 1;
        end
        chk("R3", "col_sel", int'(col_sel), lit ? (1 << col) : 0);
        chk("R4/R5", "row_lo", int'(row_lo), lit ? glyph(m_lo, col) : 0);
        chk("R4/R6", "row_hi", int'(row_hi), lit ? glyph(int'(bus_data[11:6]), col) : 0);
        chk("R7", "busy", int'(busy), (m_mode == 1) ? 1 : 0);
        chk("R2", "pos_sel", int'(pos_sel), m_pos);
    endtask

    task automatic advance();
        if (clr) begin
            m_mode = 0;                                  // R9
        end else if (start && m_mode != 1) begin
            m_mode = 1; m_el = 0; m_pos = int'(bus_data[15:12]);
        end else if (m_mode == 1) begin
            if (m_el % (C + 1) == 0) m_lo = int'(bus_data[5:0]);
            m_el++;
            if (m_el == 5 * (C + 1)) begin m_mode = 2; m_hold = 0; end
        end else if (m_mode == 2) begin
            m_hold++;
            if (m_hold == G) m_mode = 0;                 // R8
        end
    endtask

    task automatic cyc(logic s, logic c, logic [15:0] b);
        @(negedge clk);
        start = s; clr = c; bus_data = b;
        #1 compare();
        @(posedge clk);
        advance();
    endtask

    function automatic logic [15:0] rnd();
        seed = seed * 1103515245 + 12345;
        return seed[23:8];
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "col_sel", int'(col_sel), 0);
        chk("R1", "row_lo", int'(row_lo), 0);
        chk("R1", "row_hi", int'(row_hi), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "pos_sel", int'(pos_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) cyc(0, 0, 16'h0000);

        // R2 R3 R4: steady bus, full scan, hold and expiry (R8)
        ctx = "steady scan R8";
        cyc(1, 0, {4'h5, 6'd20, 6'd3});
        repeat (30) cyc(0, 0, {4'h5, 6'd20, 6'd3});

        // R5 R6 R7: live bus changing every cycle, starts while busy
        ctx = "live bus R7";
        cyc(1, 0, {4'hA, 6'd63, 6'd40});
        for (int i = 0; i < 18; i++) cyc((i % 4) == 1, 0, rnd());
        // R8: start accepted during hold
        ctx = "start in hold R8";
        repeat (4) cyc(0, 0, rnd());
        cyc(1, 0, {4'h3, 6'd7, 6'd9});
        repeat (8) cyc(0, 0, rnd());

        // R9: clear mid-scan, clear together with start
        ctx = "clear R9";
        cyc(0, 1, rnd());
        repeat (3) cyc(0, 0, rnd());
        cyc(1, 1, {4'hF, 6'd1, 6'd2});
        repeat (2) cyc(0, 0, rnd());
        cyc(1, 0, {4'hC, 6'd50, 6'd60});
        repeat (30) cyc(0, 0, rnd());

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule